// File: doc/BRIEF.md
# Health-Gated Seed Conditioner and Distributor

This block turns a stream of 256-bit raw entropy samples into 256-bit seeds. Each sample comes in on a valid/ready input with a tag that marks it healthy or unhealthy. Accepted samples are folded one after another into a running state by a keyed XOR-and-rotate step. The chaining works like a block-cipher MAC: the running state is combined with the new block, then passed through a fixed keyed transform. When the second healthy sample has been absorbed, the running state becomes a finished seed and the state starts over from zero. No entropy is carried from one seed into the next.

Finished seeds are dealt out in strict turn to two consumers, each on its own valid/ready output. One feeds an internal deterministic generator. The other feeds a seed queue that software can read. A seed goes to exactly one of them. If the consumer whose turn it is does not take the seed, the block waits for it and never hands the seed to the other consumer. An enable input from the health monitor holds back all seed output until it is raised.

Top module: `seed_mixer_top`

## Requirements
- R1: After reset, in_ready is 1 and both output valids are 0. The running state and the healthy count are cleared. The first seed after reset goes to the generator port, even when reset arrived in the middle of gathering a seed.
- R2: The running state starts at zero. For each accepted sample b the state becomes rotl(state XOR b, ROT) XOR KEY, where rotl is a left rotation of the 256-bit word and the defaults are ROT=13 and KEY = the 64-bit word C3A596F00F695A3C repeated four times. The seed is the state after the completing sample.
- R3: A seed is produced in the same cycle that the second healthy sample since the last seed is accepted. Two healthy samples a then b give the seed E(E(0 XOR a) XOR b), where E(x) = rotl(x, ROT) XOR KEY.
- R4: An unhealthy sample is still mixed into the running state but does not count toward the two healthy samples. No seed appears until the second healthy sample, however many unhealthy samples come in between.
- R5: Successive seeds alternate: generator, external, generator, and so on. At any time at most one output valid is high. The seed bus of the port that does not have the turn reads zero.
- R6: When the consumer whose turn it is holds ready low, the block stalls. That port's valid stays high with a stable seed, the other port's valid stays low even if its ready is high, and in_ready stays low.
- R7: While enable is 0, both output valids are 0. A seed that is already finished is kept and is presented on the correct port once enable is 1.
- R8: After a seed is delivered, the next seed depends only on samples accepted after the seed was finished.
- R9: While a finished seed waits for delivery, in_ready is 0. A sample offered during that time is not absorbed and has no effect on later seeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Health-monitor release; 0 blocks all seed output |
| in_valid | input | 1 | A raw sample is offered |
| in_ready | output | 1 | The block can absorb a sample |
| in_data | input | 256 | Raw entropy sample |
| in_healthy | input | 1 | 1 marks the offered sample healthy |
| gen_valid | output | 1 | Seed offered to the internal generator |
| gen_ready | input | 1 | Internal generator takes the seed |
| gen_seed | output | 256 | Seed for the internal generator (zero when not its turn) |
| ext_valid | output | 1 | Seed offered to the external seed queue |
| ext_ready | input | 1 | External queue takes the seed |
| ext_seed | output | 256 | Seed for the external queue (zero when not its turn) |

## Verification
The bench walks a health-tag pattern with runs of unhealthy samples both before and between healthy ones. A design that counted unhealthy samples would emit seeds early, and one that dropped unhealthy samples from the mix would give wrong seed values. It stalls the turn consumer while the other consumer is ready and a sample is being offered. That catches a design that skips ahead to the idle consumer, one that absorbs the offered sample into the next seed, or one that lets the held seed change. It also holds back enable while a seed is finished, and resets partway through a seed. These catch a leaked or lost seed, and a pointer or partial state that survives reset.

// File: rtl/seed_mix_pkg.sv
package seed_mix_pkg;

    typedef enum logic {
        DEST_GEN = 1'b0,
        DEST_EXT = 1'b1
    } dest_e;

    localparam int unsigned SEED_W_DEF  = 256;
    localparam int unsigned ROT_DEF     = 13;
    localparam int unsigned NEED_DEF    = 2;

endpackage

// File: rtl/seed_absorb.sv
module seed_absorb #(
    parameter int unsigned W    = 256,
    parameter int unsigned ROT  = 13,
    parameter int unsigned NEED = 2,
    parameter logic [W-1:0] KEY = {4{64'hC3A5_96F0_0F69_5A3C}}
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         acc_i,
    input  logic [W-1:0] data_i,
    input  logic         healthy_i,
    output logic         done_o,
    output logic [W-1:0] seed_o
);
    localparam int unsigned CW = $clog2(NEED + 1);

    typedef struct packed {
        logic [W-1:0]  run;
        logic [CW-1:0] cnt;
    } absorb_t;

    absorb_t st_q, st_d;
    logic [W-1:0] xored;
    logic [W-1:0] mixed;
    logic         last_one;

    always_comb begin
        xored    = st_q.run ^ data_i;
        mixed    = {xored[W-1-ROT:0], xored[W-1:W-ROT]} ^ KEY;
        last_one = healthy_i && (st_q.cnt == CW'(NEED - 1));
        st_d     = st_q;
        done_o   = 1'b0;
        seed_o   = mixed;
        if (acc_i) begin
            if (last_one) begin
                done_o   = 1'b1;
                st_d.run = '0;
                st_d.cnt = '0;
            end else begin
                st_d.run = mixed;
                st_d.cnt = st_q.cnt + CW'(healthy_i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < CW'(NEED));

    // R8
    fresh_after_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (st_q.run == '0) && (st_q.cnt == '0));

endmodule

// File: rtl/seed_steer.sv
module seed_steer
    import seed_mix_pkg::*;
#(
    parameter int unsigned W = 256
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] seed_i,
    input  logic         enable_i,
    input  logic         gen_ready_i,
    input  logic         ext_ready_i,
    output logic         full_o,
    output logic         gen_valid_o,
    output logic [W-1:0] gen_seed_o,
    output logic         ext_valid_o,
    output logic [W-1:0] ext_seed_o
);
    typedef struct packed {
        logic         full;
        dest_e        ptr;
        logic [W-1:0] seed;
    } steer_t;

    steer_t st_q, st_d;
    logic   offer;
    logic   fire;

    always_comb begin
        offer       = st_q.full && enable_i;
        gen_valid_o = offer && (st_q.ptr == DEST_GEN);
        ext_valid_o = offer && (st_q.ptr == DEST_EXT);
        gen_seed_o  = (st_q.ptr == DEST_GEN) ? st_q.seed : '0;
        ext_seed_o  = (st_q.ptr == DEST_EXT) ? st_q.seed : '0;
        fire        = (gen_valid_o && gen_ready_i) || (ext_valid_o && ext_ready_i);
        full_o      = st_q.full;
        st_d        = st_q;
        if (fire) begin
            st_d.full = 1'b0;
            st_d.ptr  = (st_q.ptr == DEST_GEN) ? DEST_EXT : DEST_GEN;
            st_d.seed = '0;
        end
        if (load_i) begin
            st_d.full = 1'b1;
            st_d.seed = seed_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{full: 1'b0, ptr: DEST_GEN, seed: '0};
        end else begin
            st_q <= st_d;
        end
    end

    // R9
    load_only_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !st_q.full);

    // R5
    no_dual_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(gen_valid_o && ext_valid_o));

    // R5
    gen_then_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_valid_o && gen_ready_i) |=> !gen_valid_o);

    // R5
    ext_then_gen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_valid_o && ext_ready_i) |=> !ext_valid_o);

    // R6
    gen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_valid_o && !gen_ready_i) |=> st_q.full && $stable(gen_seed_o));

    // R6
    ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_valid_o && !ext_ready_i) |=> st_q.full && $stable(ext_seed_o));

    // R7
    enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |-> !gen_valid_o && !ext_valid_o);

endmodule

// File: rtl/seed_mixer_top.sv
module seed_mixer_top
    import seed_mix_pkg::*;
#(
    parameter int unsigned W    = SEED_W_DEF,
    parameter int unsigned ROT  = ROT_DEF,
    parameter int unsigned NEED = NEED_DEF,
    parameter logic [W-1:0] KEY = {4{64'hC3A5_96F0_0F69_5A3C}}
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    input  logic         in_healthy,
    output logic         gen_valid,
    input  logic         gen_ready,
    output logic [W-1:0] gen_seed,
    output logic         ext_valid,
    input  logic         ext_ready,
    output logic [W-1:0] ext_seed
);
    logic         full;
    logic         accept;
    logic         done;
    logic [W-1:0] fresh_seed;

    always_comb begin
        in_ready = !full;
        accept   = in_valid && in_ready;
    end

    seed_absorb #(
        .W    (W),
        .ROT  (ROT),
        .NEED (NEED),
        .KEY  (KEY)
    ) u_absorb (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_i     (accept),
        .data_i    (in_data),
        .healthy_i (in_healthy),
        .done_o    (done),
        .seed_o    (fresh_seed)
    );

    seed_steer #(
        .W (W)
    ) u_steer (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (done),
        .seed_i      (fresh_seed),
        .enable_i    (enable),
        .gen_ready_i (gen_ready),
        .ext_ready_i (ext_ready),
        .full_o      (full),
        .gen_valid_o (gen_valid),
        .gen_seed_o  (gen_seed),
        .ext_valid_o (ext_valid),
        .ext_seed_o  (ext_seed)
    );

    // R9
    busy_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_valid || ext_valid) |-> !in_ready);

endmodule

// File: tb/seed_mixer_top_tb.sv
module seed_mixer_top_tb;
    localparam int W   = 256;
    localparam int ROT = 13;
    localparam logic [W-1:0] KEY = {4{64'hC3A5_96F0_0F69_5A3C}};
    localparam int NT  = 17;
    localparam bit HTAB [0:NT-1] = '{1,1, 1,0,1, 0,0,1,1, 1,0,0,1, 0,1,0,1};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         enable = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [W-1:0] in_data = '0;
    logic         in_healthy = 1'b0;
    logic         gen_valid, ext_valid;
    logic         gen_ready = 1'b0, ext_ready = 1'b0;
    logic [W-1:0] gen_seed, ext_seed;

    int checks = 0;
    int failures = 0;
    logic [W-1:0] mstate;
    int           mcnt;
    bit           mptr;

    always #4 clk = ~clk;

    seed_mixer_top u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_healthy(in_healthy),
        .gen_valid(gen_valid), .gen_ready(gen_ready), .gen_seed(gen_seed),
        .ext_valid(ext_valid), .ext_ready(ext_ready), .ext_seed(ext_seed)
    );

    function automatic logic [W-1:0] emix(logic [W-1:0] s, logic [W-1:0] b);
        logic [W-1:0] x;
        x = s ^ b;
        return ((x << ROT) | (x >> (W - ROT))) ^ KEY;
    endfunction

    function automatic logic [W-1:0] samp(int i);
        logic [W-1:0] r;
        for (int k = 0; k < 8; k++) r[k*32 +: 32] = 32'(i * 8 + k + 1) * 32'h9E37_79B9;
        return r;
    endfunction

    task automatic chk(bit ok, string tag, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        gen_ready = 1'b0;
        ext_ready = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        mstate = '0;
        mcnt = 0;
        mptr = 1'b0;
    endtask

    // Send one sample and update the bench model; returns 1 when a seed should be finished.
    task automatic send(logic [W-1:0] d, bit h, output bit completes, output logic [W-1:0] seed);
        @(negedge clk);
        chk(in_ready == 1'b1, "R9 in_ready before sample", W'(in_ready), W'(1));
        in_valid = 1'b1;
        in_data = d;
        in_healthy = h;
        @(negedge clk);
        in_valid = 1'b0;
        mstate = emix(mstate, d);
        completes = 1'b0;
        seed = mstate;
        if (h) mcnt++;
        if (mcnt == 2) begin
            completes = 1'b1;
            mstate = '0;
            mcnt = 0;
        end
    endtask

    task automatic take(logic [W-1:0] exp, string tag);
        logic [W-1:0] act;
        @(negedge clk);
        if (!mptr) begin
            chk(gen_valid === 1'b1 && ext_valid === 1'b0, {tag, " R5 gen turn valids"},
                W'({gen_valid, ext_valid}), W'(2'b10));
            chk(gen_seed === exp, {tag, " R2 gen seed"}, gen_seed, exp);
            chk(ext_seed === '0, {tag, " R5 idle ext bus zero"}, ext_seed, '0);
            gen_ready = 1'b1;
        end else begin
            chk(ext_valid === 1'b1 && gen_valid === 1'b0, {tag, " R5 ext turn valids"},
                W'({gen_valid, ext_valid}), W'(2'b01));
            act = ext_seed;
            chk(act === exp, {tag, " R2 ext seed"}, act, exp);
            chk(gen_seed === '0, {tag, " R5 idle gen bus zero"}, gen_seed, '0);
            ext_ready = 1'b1;
        end
        @(negedge clk);
        gen_ready = 1'b0;
        ext_ready = 1'b0;
        chk(gen_valid === 1'b0 && ext_valid === 1'b0, {tag, " R5 seed delivered once"},
            W'({gen_valid, ext_valid}), W'(0));
        mptr = ~mptr;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        bit c;
        logic [W-1:0] s, s2;

        do_reset();
        @(negedge clk);
        chk(in_ready === 1'b1, "R1 reset in_ready", W'(in_ready), W'(1));
        chk(gen_valid === 1'b0 && ext_valid === 1'b0, "R1 reset valids",
            W'({gen_valid, ext_valid}), W'(0));

        // Table walk: health patterns, expected seeds from the bench model (R2 R3 R4 R5)
        for (int i = 0; i < NT; i++) begin
            send(samp(i), HTAB[i], c, s);
            if (c) begin
                take(s, $sformatf("R3 table seed at %0d", i));
            end else begin
                chk(gen_valid === 1'b0 && ext_valid === 1'b0,
                    $sformatf("R4 no early seed at %0d", i), W'({gen_valid, ext_valid}), W'(0));
            end
        end

        // Stall: turn consumer not ready, other ready, a sample offered (R6 R9)
        send(samp(100), 1'b1, c, s);
        send(samp(101), 1'b1, c, s);
        @(negedge clk);
        if (mptr) gen_ready = 1'b1; else ext_ready = 1'b1;
        in_valid = 1'b1;
        in_data = samp(555);
        in_healthy = 1'b1;
        repeat (3) @(negedge clk);
        chk(in_ready === 1'b0, "R9 in_ready low while seed waits", W'(in_ready), W'(0));
        chk(mptr ? (gen_valid === 1'b0 && ext_valid === 1'b1) : (gen_valid === 1'b1 && ext_valid === 1'b0),
            "R6 no skip to idle consumer", W'({gen_valid, ext_valid}), W'(mptr ? 2'b01 : 2'b10));
        chk((mptr ? ext_seed : gen_seed) === s, "R6 held seed stable", mptr ? ext_seed : gen_seed, s);
        in_valid = 1'b0;
        gen_ready = 1'b0;
        ext_ready = 1'b0;
        take(s, "R6 stalled seed");
        send(samp(102), 1'b1, c, s);
        send(samp(103), 1'b1, c, s2);
        s = emix(emix('0, samp(102)), samp(103));
        chk(s2 === s, "R8 model fresh state", s2, s);
        take(s, "R9 offered sample ignored");

        // Enable gating (R7)
        @(negedge clk);
        enable = 1'b0;
        send(samp(200), 1'b0, c, s);
        send(samp(201), 1'b1, c, s);
        send(samp(202), 1'b1, c, s);
        @(negedge clk);
        gen_ready = 1'b1;
        ext_ready = 1'b1;
        repeat (3) @(negedge clk);
        chk(gen_valid === 1'b0 && ext_valid === 1'b0, "R7 enable low blocks output",
            W'({gen_valid, ext_valid}), W'(0));
        chk(in_ready === 1'b0, "R7 finished seed retained", W'(in_ready), W'(0));
        gen_ready = 1'b0;
        ext_ready = 1'b0;
        enable = 1'b1;
        take(s, "R7 released seed");

        // Reset in mid-gather, with pointer pointing at ext (R1 R8)
        send(samp(300), 1'b1, c, s);
        send(samp(301), 1'b1, c, s);
        take(s, "R1 pre-reset seed");
        chk(mptr == 1'b1, "R1 bench pointer at ext before reset", W'(mptr), W'(1));
        send(samp(302), 1'b1, c, s);
        do_reset();
        send(samp(303), 1'b1, c, s);
        send(samp(304), 1'b1, c, s);
        take(emix(emix('0, samp(303)), samp(304)), "R1 first seed after reset to gen");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule